// File: doc/BRIEF.md
# Segmented Address Translator with Access Protection

This block turns a two-part logical address (a segment number plus an offset inside that segment) into a flat physical address. The per-segment descriptors sit in a table in ordinary memory. A table-origin register gives the table's start address and a table-size register gives the number of descriptors. Each descriptor packs a start address, a segment length, a valid flag and three permission flags: read, write and execute.

A CPU-side request brings the segment, the offset and the kind of access. The unit first checks the segment number against the table size, with no memory traffic. It then gets the descriptor, either from a one-entry cache of the last descriptor it fetched or through a single read on its memory port. It checks the valid flag, then the offset against the length, then the permission for the access kind. It answers with a one-cycle `done` pulse that carries either the translated address or a fault code. Only one request is in flight at a time. Writing either table register flushes the cache.

Top module: `seg_xlate`

## Requirements
- R1: After a synchronous active-low reset, `done` and `mem_rd` are 0, `req_ready` is 1, and the descriptor cache holds nothing.
- R2: A request with a segment number greater than or equal to the table-size register finishes with fault code 1. Its `done` pulse comes in the cycle after acceptance and no memory read is issued.
- R3: On a cache miss the unit issues exactly one `mem_rd` pulse at address table-origin plus segment number, in the cycle after acceptance. `done` follows in the cycle after the cycle in which `mem_rvalid` is sampled high.
- R4: A descriptor whose valid flag (bit 3) is 0 gives fault code 2.
- R5: An offset greater than or equal to the descriptor length (bits 16..4) gives fault code 3. An offset equal to the length minus one is accepted.
- R6: Access kinds are encoded as 0 read, 1 write, 2 execute and 3 none. Each needs its flag set: read is bit 2, write bit 1, execute bit 0. A kind whose flag is clear, and kind 3 in every case, gives fault code 4.
- R7: When several faults apply, the lowest-numbered one is reported, in the order 1, 2, 3, 4.
- R8: With no fault, `fault` is 0 and `phys_addr` is the descriptor start (bits 32..17) plus the offset. With any fault, `phys_addr` is 0.
- R9: A request for the segment whose descriptor was fetched last is served from the cache. It issues no memory read and its `done` comes in the cycle after acceptance.
- R10: A write to either table register (`cfg_sel` 0 for the origin, 1 for the size) empties the cache, so the next request fetches its descriptor again.
- R11: While a fetch is outstanding, `req_ready` is 0 and any `req_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table register write strobe |
| cfg_sel | input | 1 | 0 writes table origin, 1 writes table size |
| cfg_wdata | input | PA_W | Table register write data |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Unit idle and able to accept |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access kind |
| mem_rd | output | 1 | Descriptor read pulse |
| mem_addr | output | PA_W | Descriptor address |
| mem_rvalid | input | 1 | Descriptor data valid |
| mem_rdata | input | PA_W+OFF_W+5 | Descriptor {start, length, valid, r, w, x} |
| done | output | 1 | Result pulse |
| fault | output | 3 | Fault code, 0 when none |
| phys_addr | output | PA_W | Translated address |

## Verification
The bench probes the length boundary from both sides: offset length-1 must pass and offset equal to the length must fault. A comparison off by one would flip one of the two. It also stacks faults on one request: an invalid descriptor together with an oversized offset, and an oversized offset together with a missing permission. A wrong priority chain would then report the later code. Requests at and past the table size must fault with no memory read, which catches a design that fetches first. The bench also counts memory reads across repeated segments, across a table-register write, and while extra requests arrive during a fetch. A stale or never-cleared cache, or a unit that accepts work while busy, shows up there as a wrong read count or as an extra `done`.

// File: rtl/seg_xlate_pkg.sv
// Shared encodings for the segmented address translator.
// Assumes: fault codes and access kinds are fixed by the block's contract.
package seg_xlate_pkg;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_RANGE   = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_LIMIT   = 3'd3,
        FLT_PRIV    = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } state_e;

endpackage

// File: rtl/seg_check.sv
// Combinational protection check and address add for one descriptor.
// Assumes: OFF_W <= PA_W; range_bad is already resolved by the caller.
module seg_check #(
    parameter int PA_W  = 16,
    parameter int OFF_W = 12
) (
    input  logic             range_bad,
    input  logic [PA_W-1:0]  ent_base,
    input  logic [OFF_W:0]   ent_len,
    input  logic             ent_valid,
    input  logic [2:0]       ent_perm,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       acc,
    output logic [2:0]       fault,
    output logic [PA_W-1:0]  phys
);
    import seg_xlate_pkg::*;

    logic allowed;

    // pick the permission flag matching the access kind
    always_comb begin
        unique case (acc_e'(acc))
            ACC_READ:  allowed = ent_perm[2];
            ACC_WRITE: allowed = ent_perm[1];
            ACC_EXEC:  allowed = ent_perm[0];
            default:   allowed = 1'b0;
        endcase
    end

    // priority chain of faults, then the address sum on success
    always_comb begin
        phys = '0;
        if (range_bad)                      fault = FLT_RANGE;
        else if (!ent_valid)                fault = FLT_INVALID;
        else if ({1'b0, off} >= ent_len)    fault = FLT_LIMIT;
        else if (!allowed)                  fault = FLT_PRIV;
        else begin
            fault = FLT_NONE;
            phys  = ent_base + PA_W'(off);
        end
    end
endmodule

// File: rtl/seg_cache.sv
// One-entry descriptor cache tagged by segment number.
// Assumes: clr and fill are never asserted in the same cycle by the top.
module seg_cache #(
    parameter int SEG_W   = 4,
    parameter int ENTRY_W = 33
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               fill,
    input  logic [SEG_W-1:0]   fill_tag,
    input  logic [ENTRY_W-1:0] fill_data,
    input  logic [SEG_W-1:0]   look_tag,
    output logic               hit,
    output logic [ENTRY_W-1:0] data
);
    logic               vld_q;
    logic [SEG_W-1:0]   tag_q;
    logic [ENTRY_W-1:0] dat_q;

    // hold the last fetched descriptor; flush on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            vld_q <= 1'b0;
        end else if (fill) begin
            vld_q <= 1'b1;
        end
        if (fill) begin
            tag_q <= fill_tag;
            dat_q <= fill_data;
        end
    end

    assign hit  = vld_q && (tag_q == look_tag);
    assign data = dat_q;
endmodule

// File: rtl/seg_xlate.sv
// Segmented address translator: range check, descriptor fetch or cache hit,
// protection checks, then start plus offset or a fault code.
// Assumes: table registers are not written while a fetch is outstanding;
// memory returns exactly one mem_rvalid per mem_rd.
module seg_xlate #(
    parameter int SEG_W = 4,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic                       cfg_sel,
    input  logic [PA_W-1:0]            cfg_wdata,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [SEG_W-1:0]           req_seg,
    input  logic [OFF_W-1:0]           req_off,
    input  logic [1:0]                 req_acc,
    output logic                       mem_rd,
    output logic [PA_W-1:0]            mem_addr,
    input  logic                       mem_rvalid,
    input  logic [PA_W+OFF_W+4:0]      mem_rdata,
    output logic                       done,
    output logic [2:0]                 fault,
    output logic [PA_W-1:0]            phys_addr
);
    import seg_xlate_pkg::*;

    localparam int LEN_W   = OFF_W + 1;
    localparam int ENTRY_W = PA_W + LEN_W + 4;
    localparam int CNT_W   = SEG_W + 1;

    state_e             state_q;
    logic [PA_W-1:0]    tbl_base_q;
    logic [CNT_W-1:0]   tbl_len_q;
    logic [SEG_W-1:0]   seg_q;
    logic [OFF_W-1:0]   off_q;
    logic [1:0]         acc_q;
    logic               done_q, mem_rd_q;
    logic [2:0]         fault_q;
    logic [PA_W-1:0]    phys_q, mem_addr_q;

    logic               accept, range_bad, c_hit, fill;
    logic [ENTRY_W-1:0] c_data, ent;
    logic [OFF_W-1:0]   chk_off;
    logic [1:0]         chk_acc;
    logic [2:0]         chk_fault;
    logic [PA_W-1:0]    chk_phys;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign range_bad = (state_q == ST_IDLE) && ({1'b0, req_seg} >= tbl_len_q);
    assign fill      = (state_q == ST_FETCH) && mem_rvalid;

    // checker input source: fetched descriptor while fetching, else cache
    always_comb begin
        if (state_q == ST_FETCH) begin
            ent     = mem_rdata;
            chk_off = off_q;
            chk_acc = acc_q;
        end else begin
            ent     = c_data;
            chk_off = req_off;
            chk_acc = req_acc;
        end
    end

    seg_cache #(.SEG_W(SEG_W), .ENTRY_W(ENTRY_W)) u_cache (
        .clk(clk), .rst_n(rst_n), .clr(cfg_we), .fill(fill),
        .fill_tag(seg_q), .fill_data(mem_rdata), .look_tag(req_seg),
        .hit(c_hit), .data(c_data)
    );

    seg_check #(.PA_W(PA_W), .OFF_W(OFF_W)) u_check (
        .range_bad(range_bad),
        .ent_base(ent[ENTRY_W-1 -: PA_W]),
        .ent_len(ent[4 +: LEN_W]),
        .ent_valid(ent[3]),
        .ent_perm(ent[2:0]),
        .off(chk_off), .acc(chk_acc),
        .fault(chk_fault), .phys(chk_phys)
    );

    // table origin and size registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_base_q <= '0;
            tbl_len_q  <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) tbl_len_q  <= cfg_wdata[CNT_W-1:0];
            else         tbl_base_q <= cfg_wdata;
        end
    end

    // request sequencing: immediate answer, or fetch then answer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            done_q     <= 1'b0;
            mem_rd_q   <= 1'b0;
            fault_q    <= FLT_NONE;
            phys_q     <= '0;
            mem_addr_q <= '0;
            seg_q      <= '0;
            off_q      <= '0;
            acc_q      <= '0;
        end else begin
            done_q   <= 1'b0;
            mem_rd_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    if (range_bad || c_hit) begin
                        done_q  <= 1'b1;
                        fault_q <= chk_fault;
                        phys_q  <= chk_phys;
                    end else begin
                        mem_rd_q   <= 1'b1;
                        mem_addr_q <= tbl_base_q + PA_W'(req_seg);
                        seg_q      <= req_seg;
                        off_q      <= req_off;
                        acc_q      <= req_acc;
                        state_q    <= ST_FETCH;
                    end
                end
                ST_FETCH: if (mem_rvalid) begin
                    done_q  <= 1'b1;
                    fault_q <= chk_fault;
                    phys_q  <= chk_phys;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done      = done_q;
    assign fault     = fault_q;
    assign phys_addr = phys_q;
    assign mem_rd    = mem_rd_q;
    assign mem_addr  = mem_addr_q;
endmodule

// File: rtl/seg_xlate_chk.sv
// Protocol and result checks for seg_xlate, attached by bind.
// Assumes: tbl_len is the translator's table-size register.
module seg_xlate_chk #(
    parameter int SEG_W = 4,
    parameter int PA_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [SEG_W-1:0] req_seg,
    input logic [SEG_W:0]   tbl_len,
    input logic             mem_rd,
    input logic             mem_rvalid,
    input logic             done,
    input logic [2:0]       fault,
    input logic [PA_W-1:0]  phys_addr
);
    // R2
    range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ({1'b0, req_seg} >= tbl_len))
        |=> (done && fault == 3'd1 && !mem_rd));

    // R3
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R3
    fetch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rvalid && !req_ready) |=> done);

    // R7
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault <= 3'd4));

    // R8
    fault_phys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 3'd0) |-> (phys_addr == '0));

    // R11
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !req_ready);
endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .tbl_len(tbl_len_q), .mem_rd(mem_rd),
    .mem_rvalid(mem_rvalid), .done(done), .fault(fault), .phys_addr(phys_addr)
);

// File: tb/sim_seg_xlate.sv
// Self-checking bench: vector table walk, then directed reset and corner tests.
module sim_seg_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam logic [15:0] TBL_ORG = 16'h0100;
    localparam int NVEC = 14;

    // {seg[21:18], off[17:6], acc[5:4], fault[3:1], hit[0]}
    localparam logic [21:0] VEC [NVEC] = '{
        {4'd0, 12'h010, 2'd0, 3'd0, 1'b0},
        {4'd0, 12'h0FF, 2'd0, 3'd0, 1'b1},
        {4'd0, 12'h100, 2'd0, 3'd3, 1'b1},
        {4'd0, 12'h010, 2'd1, 3'd4, 1'b1},
        {4'd1, 12'h020, 2'd1, 3'd0, 1'b0},
        {4'd1, 12'h020, 2'd2, 3'd4, 1'b1},
        {4'd2, 12'h000, 2'd2, 3'd0, 1'b0},
        {4'd2, 12'h200, 2'd0, 3'd3, 1'b1},
        {4'd3, 12'hFFF, 2'd0, 3'd2, 1'b0},
        {4'd6, 12'h000, 2'd0, 3'd1, 1'b1},
        {4'd15, 12'h000, 2'd0, 3'd1, 1'b1},
        {4'd4, 12'h010, 2'd3, 3'd4, 1'b0},
        {4'd5, 12'h13F, 2'd1, 3'd0, 1'b0},
        {4'd5, 12'h13F, 2'd0, 3'd4, 1'b1}
    };

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0, cfg_sel = 0;
    logic [15:0] cfg_wdata = 0;
    logic req_valid = 0, req_ready;
    logic [3:0] req_seg = 0;
    logic [11:0] req_off = 0;
    logic [1:0] req_acc = 0;
    logic mem_rd, mem_rvalid = 0;
    logic [15:0] mem_addr;
    logic [32:0] mem_rdata = 0;
    logic done;
    logic [2:0] fault;
    logic [15:0] phys_addr;

    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .fault(fault), .phys_addr(phys_addr)
    );

    // descriptor model: start, length, valid, r, w, x per table slot
    function automatic logic [32:0] desc(input int i);
        logic [15:0] b;
        logic [12:0] l;
        logic [2:0]  p;
        b = 16'h2000 + 16'(i) * 16'h0400;
        l = 13'h100 + 13'(i) * 13'h040;
        case (i)
            0: p = 3'b100;
            1: p = 3'b110;
            2: p = 3'b001;
            5: p = 3'b010;
            default: p = 3'b111;
        endcase
        return {b, l, (i != 3), p};
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // issue one request, serve the memory port, record the outcome
    task automatic run_req(input logic [3:0] s, input logic [11:0] o,
                           input logic [1:0] a, output logic [2:0] f,
                           output logic [15:0] p, output int reads,
                           output int dcyc, output int rcyc,
                           output logic [15:0] addr, output int busy_rdy);
        int pend;
        logic [15:0] acap;
        @(negedge clk);
        req_valid = 1; req_seg = s; req_off = o; req_acc = a;
        @(negedge clk);
        req_valid = 0;
        reads = 0; dcyc = -1; rcyc = -1; pend = -1; busy_rdy = 0;
        acap = 0; f = 0; p = 0;
        for (int cyc = 1; cyc <= 30; cyc++) begin
            if (cyc > 1) @(negedge clk);
            if (mem_rvalid) mem_rvalid = 0;
            if (done) begin
                dcyc = cyc; f = fault; p = phys_addr;
                break;
            end
            if (reads > 0 && req_ready) busy_rdy++;
            if (mem_rd) begin
                reads++; acap = mem_addr; pend = LAT;
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_rvalid = 1;
                    mem_rdata  = desc(int'(acap - TBL_ORG));
                    rcyc = cyc;
                    pend = -1;
                end
            end
        end
        addr = acap;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [2:0] f;
        logic [15:0] p, addr, ep;
        int reads, dcyc, rcyc, br;
        logic [3:0] s;
        logic [11:0] o;
        logic [2:0] ef;
        logic eh;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 0, "R1", "done", done, 0);
        chk(mem_rd == 0, "R1", "mem_rd", mem_rd, 0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1, "R1", "req_ready", req_ready, 1);

        cfg_write(1'b0, TBL_ORG);
        cfg_write(1'b1, 16'd6);

        // vector table walk: R2 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            {s, o, ef, eh} = {VEC[i][21:18], VEC[i][17:6], VEC[i][3:1], VEC[i][0]};
            run_req(s, o, VEC[i][5:4], f, p, reads, dcyc, rcyc, addr, br);
            ep = (ef == 0) ? desc(int'(s))[32:17] + 16'(o) : 16'h0;
            chk(f == ef, "R7", $sformatf("fault vec%0d", i), f, ef);
            chk(p == ep, "R8", $sformatf("phys vec%0d", i), p, ep);
            if (eh) begin
                chk(reads == 0, ef == 1 ? "R2" : "R9", $sformatf("reads vec%0d", i), reads, 0);
                chk(dcyc == 1, ef == 1 ? "R2" : "R9", $sformatf("latency vec%0d", i), dcyc, 1);
            end else begin
                chk(reads == 1, "R3", $sformatf("reads vec%0d", i), reads, 1);
                chk(addr == TBL_ORG + 16'(s), "R3", $sformatf("addr vec%0d", i), addr, TBL_ORG + 16'(s));
                chk(dcyc == rcyc + 1, "R3", $sformatf("latency vec%0d", i), dcyc, rcyc + 1);
                chk(br == 0, "R11", $sformatf("ready while busy vec%0d", i), br, 0);
            end
        end

        // R10: size write flushes the cache; segment 5 fetches again
        cfg_write(1'b1, 16'd6);
        run_req(4'd5, 12'h001, 2'd1, f, p, reads, dcyc, rcyc, addr, br);
        chk(reads == 1, "R10", "refetch after size write", reads, 1);
        chk(p == 16'h3401, "R10", "phys after refetch", p, 16'h3401);
        // R10: origin write flushes too
        cfg_write(1'b0, TBL_ORG);
        run_req(4'd5, 12'h001, 2'd1, f, p, reads, dcyc, rcyc, addr, br);
        chk(reads == 1, "R10", "refetch after origin write", reads, 1);

        // R5: boundary on segment 4 (length 0x200)
        run_req(4'd4, 12'h1FF, 2'd2, f, p, reads, dcyc, rcyc, addr, br);
        chk(f == 0 && p == 16'h31FF, "R5", "len-1 accepted", {f, p}, {3'd0, 16'h31FF});
        run_req(4'd4, 12'h200, 2'd2, f, p, reads, dcyc, rcyc, addr, br);
        chk(f == 3, "R5", "len rejected", f, 3);
        // R2: size reduced, segment 4 now out of range without a read
        cfg_write(1'b1, 16'd4);
        run_req(4'd4, 12'h000, 2'd0, f, p, reads, dcyc, rcyc, addr, br);
        chk(f == 1 && reads == 0, "R2", "size boundary", {f, 8'(reads)}, {3'd1, 8'd0});

        // R11: request held during a fetch is ignored
        begin
            int dones = 0;
            @(negedge clk);
            req_valid = 1; req_seg = 4'd1; req_off = 12'h004; req_acc = 2'd0;
            @(negedge clk);
            req_seg = 4'd0;  // different request while busy
            chk(mem_rd == 1 && req_ready == 0, "R11", "busy after accept",
                {mem_rd, req_ready}, 2'b10);
            @(negedge clk);
            req_valid = 0;
            @(negedge clk);
            mem_rvalid = 1; mem_rdata = desc(1);
            @(negedge clk);
            mem_rvalid = 0;
            chk(done == 1 && fault == 0 && phys_addr == 16'h2404, "R11",
                "first request result", {done, fault, phys_addr}, {1'b1, 3'd0, 16'h2404});
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (done || mem_rd) dones++;
            end
            chk(dones == 0, "R11", "ignored request produced activity", dones, 0);
        end

        // R1: reset mid-idle clears cache: segment 1 must fetch again
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        cfg_write(1'b0, TBL_ORG);
        cfg_write(1'b1, 16'd6);
        run_req(4'd1, 12'h004, 2'd0, f, p, reads, dcyc, rcyc, addr, br);
        chk(reads == 1, "R1", "cache empty after reset", reads, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule